// File: doc/BRIEF.md
# DMA Channel Interrupt Hub

This block collects completion events from a set of DMA channels and turns them into a single interrupt line. Each channel keeps a sticky status word with five event causes and a matching cause-enable word. When the AND of the two goes from all-zero to non-zero, the channel's bit in a global pending word is set. The interrupt output is high while any pending bit is also set in a global enable word. Each channel also has a start/stop control bit driven to the transfer engine, and a global idle word shows which channels report no activity.

The two levels are cleared separately. Software can therefore clear a pending bit while the channel's status is still non-zero. In that state, further causes on the same channel do not set pending again. The driver detects this by reading channel status against pending. It recovers by clearing the channel status, after which the next enabled cause raises pending again. All registers are reached through a plain single-cycle write strobe and an address-decoded, combinational read bus.

Top module: `dma_irq_hub`

## Requirements
- R1: After reset, pending, global enable, every cause-enable, every status, every run bit and the interrupt output are all zero.
- R2: A one-cycle pulse on a cause input of channel c sets the status bit for that cause in channel c's status register at offset 0x08. The bit is visible on the cycle after the pulse and stays set until software clears it. Cause positions are bits 0..4: 0 block done, 1 list done, 2 frame done, 3 half frame, 4 last frame.
- R3: A write to a channel status register clears every status bit whose written data bit is 0 and leaves bits written as 1 unchanged.
- R4: The channel cause-enable register (offset 0x04, bits 0..4) and the global enable register (0x010, bit i for channel i) read back what was written.
- R5: Channel c's bit in the pending register (0x000, bit c) is set one clock edge after the edge at which (cause-enable AND status) of channel c changes from zero to non-zero. This includes the case where an enable write makes it non-zero.
- R6: While (cause-enable AND status) of a channel stays non-zero, new causes do not set its pending bit again. Once status is cleared to zero, the next enabled cause sets pending again.
- R7: Writing the pending register clears the bits written as 1 and leaves the bits written as 0.
- R8: When a cause event and a software clear of the same bit fall in the same cycle, the bit ends up set. This applies to status bits and to pending bits.
- R9: The interrupt output is high one cycle after any bit of (pending AND global enable) is high, and low one cycle after that AND is zero.
- R10: A channel whose global enable bit is 0 still records its pending bit but does not drive the interrupt output.
- R11: The idle register (0x02C) reads bit i as 1 exactly when busy input i is 0.
- R12: Writing a channel run register (offset 0x00) sets run output c to written bit 0. The register reads back the same value.
- R13: Channel c's registers sit at 0x100*(c+1). Any other address reads 0, and a write to it changes no register.
- R14: A status bit whose cause-enable bit is 0 does not set pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| evt_i | input | NUM_CH*NUM_CAUSE | Cause pulses, channel c at bits c*NUM_CAUSE upward |
| busy_i | input | NUM_CH | Channel activity flags from the transfer engines |
| run_o | output | NUM_CH | Per-channel start/stop control |
| irq_o | output | 1 | Aggregated interrupt, registered |

## Verification
A hardware cause and a software clear can land on the same bit in one cycle, at two levels. At the channel level, a status write that zeroes a cause meets a pulse on that cause. At the global level, a pending write-one-to-clear meets the edge at which the channel's enabled-status first turns non-zero. The bench provokes the first by driving the write and the pulse at the same edge. It provokes the second by issuing the pending clear on the cycle right after the cause pulse. In both cases it reads the bit back afterwards and expects it set.

// File: rtl/irqhub_pkg.sv
package irqhub_pkg;
  typedef enum logic [2:0] {
    RK_NONE,
    RK_PEND,
    RK_GEN,
    RK_IDLE,
    RK_RUN,
    RK_CEN,
    RK_STAT
  } reg_kind_e;

  localparam logic [7:0] OFF_PEND = 8'h00;
  localparam logic [7:0] OFF_GEN  = 8'h10;
  localparam logic [7:0] OFF_IDLE = 8'h2C;
  localparam logic [7:0] OFF_RUN  = 8'h00;
  localparam logic [7:0] OFF_CEN  = 8'h04;
  localparam logic [7:0] OFF_STAT = 8'h08;
endpackage

// File: rtl/irqhub_decode.sv
module irqhub_decode
  import irqhub_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [NUM_CH-1:0] ch_oh
);
  localparam int PG_W = ADDR_W - 8;

  logic [PG_W-1:0] page;
  logic [7:0]      off;
  logic            page_ok;

  assign page    = addr[ADDR_W-1:8];
  assign off     = addr[7:0];
  assign page_ok = (page != '0) && (page <= PG_W'(NUM_CH));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign ch_oh[i] = page_ok && (page == PG_W'(i + 1));
  end

  always_comb begin
    kind = RK_NONE;
    if (page == '0) begin
      unique case (off)
        OFF_PEND: kind = RK_PEND;
        OFF_GEN:  kind = RK_GEN;
        OFF_IDLE: kind = RK_IDLE;
        default:  kind = RK_NONE;
      endcase
    end else if (page_ok) begin
      unique case (off)
        OFF_RUN:  kind = RK_RUN;
        OFF_CEN:  kind = RK_CEN;
        OFF_STAT: kind = RK_STAT;
        default:  kind = RK_NONE;
      endcase
    end
  end
endmodule

// File: rtl/irqhub_chan.sv
module irqhub_chan #(
  parameter int NUM_CAUSE = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_run,
  input  logic                 wr_cen,
  input  logic                 wr_stat,
  input  logic [NUM_CAUSE-1:0] wdata,
  input  logic [NUM_CAUSE-1:0] evt,
  output logic                 run_o,
  output logic [NUM_CAUSE-1:0] cen_o,
  output logic [NUM_CAUSE-1:0] stat_o,
  output logic                 pend_set_o
);
  logic hit, hit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_o  <= 1'b0;
      cen_o  <= '0;
      stat_o <= '0;
      hit_q  <= 1'b0;
    end else begin
      if (wr_run) run_o <= wdata[0];
      if (wr_cen) cen_o <= wdata;
      // a cause arriving in the write cycle survives the clear
      stat_o <= (wr_stat ? (stat_o & wdata) : stat_o) | evt;
      hit_q  <= hit;
    end
  end

  assign hit        = |(cen_o & stat_o);
  assign pend_set_o = hit & ~hit_q;

  p_evt_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat_o & $past(evt)) == $past(evt)));

  p_stat_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((stat_o & ~$past(wdata) & ~$past(evt)) == '0));

  p_cen_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cen |=> (cen_o == $past(wdata)));

  p_single_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_set_o |=> !pend_set_o);

  p_run_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_run |=> (run_o == $past(wdata[0])));
endmodule

// File: rtl/irqhub_global.sv
module irqhub_global #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pend,
  input  logic              wr_gen,
  input  logic [NUM_CH-1:0] wdata,
  input  logic [NUM_CH-1:0] pend_set,
  output logic [NUM_CH-1:0] pend_o,
  output logic [NUM_CH-1:0] gen_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] w1c_mask;

  assign w1c_mask = wr_pend ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_o <= '0;
      gen_o  <= '0;
      irq_o  <= 1'b0;
    end else begin
      pend_o <= (pend_o & ~w1c_mask) | pend_set;
      if (wr_gen) gen_o <= wdata;
      irq_o  <= |(pend_o & gen_o);
    end
  end

  p_set_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_set) |=> ((pend_o & $past(pend_set)) == $past(pend_set)));

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> ((pend_o & $past(wdata) & ~$past(pend_set)) == '0));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && (|(wdata & pend_set))) |=> ((pend_o & $past(wdata & pend_set)) != '0));

  p_irq_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_o & gen_o)) |=> irq_o);

  p_irq_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend_o & gen_o)) |=> !irq_o);
endmodule

// File: rtl/dma_irq_hub.sv
module dma_irq_hub
  import irqhub_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int NUM_CAUSE = 5,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  input  logic [NUM_CH*NUM_CAUSE-1:0] evt_i,
  input  logic [NUM_CH-1:0]           busy_i,
  output logic [NUM_CH-1:0]           run_o,
  output logic                        irq_o
);
  reg_kind_e         kind;
  logic [NUM_CH-1:0] ch_oh;
  logic [NUM_CH-1:0] pend, gen, pend_set, idle;
  logic [NUM_CAUSE-1:0] cen_w  [NUM_CH];
  logic [NUM_CAUSE-1:0] stat_w [NUM_CH];

  irqhub_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
    .addr  (reg_addr),
    .kind  (kind),
    .ch_oh (ch_oh)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    irqhub_chan #(.NUM_CAUSE(NUM_CAUSE)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_run     (reg_wr && ch_oh[c] && (kind == RK_RUN)),
      .wr_cen     (reg_wr && ch_oh[c] && (kind == RK_CEN)),
      .wr_stat    (reg_wr && ch_oh[c] && (kind == RK_STAT)),
      .wdata      (reg_wdata[NUM_CAUSE-1:0]),
      .evt        (evt_i[c*NUM_CAUSE +: NUM_CAUSE]),
      .run_o      (run_o[c]),
      .cen_o      (cen_w[c]),
      .stat_o     (stat_w[c]),
      .pend_set_o (pend_set[c])
    );
  end

  irqhub_global #(.NUM_CH(NUM_CH)) u_global (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_pend  (reg_wr && (kind == RK_PEND)),
    .wr_gen   (reg_wr && (kind == RK_GEN)),
    .wdata    (reg_wdata[NUM_CH-1:0]),
    .pend_set (pend_set),
    .pend_o   (pend),
    .gen_o    (gen),
    .irq_o    (irq_o)
  );

  assign idle = ~busy_i;

  always_comb begin
    reg_rdata = '0;
    unique case (kind)
      RK_PEND: reg_rdata[NUM_CH-1:0] = pend;
      RK_GEN:  reg_rdata[NUM_CH-1:0] = gen;
      RK_IDLE: reg_rdata[NUM_CH-1:0] = idle;
      RK_RUN: begin
        for (int i = 0; i < NUM_CH; i++)
          if (ch_oh[i]) reg_rdata[0] = run_o[i];
      end
      RK_CEN: begin
        for (int i = 0; i < NUM_CH; i++)
          if (ch_oh[i]) reg_rdata[NUM_CAUSE-1:0] = cen_w[i];
      end
      RK_STAT: begin
        for (int i = 0; i < NUM_CH; i++)
          if (ch_oh[i]) reg_rdata[NUM_CAUSE-1:0] = stat_w[i];
      end
      default: reg_rdata = '0;
    endcase
  end

  p_unmapped_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == RK_NONE) |-> (reg_rdata == '0));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == RK_IDLE) |-> (reg_rdata[NUM_CH-1:0] == ~busy_i));
endmodule

// File: tb/test_dma_irq_hub.sv
module test_dma_irq_hub;
  localparam int NCH = 8;
  localparam int NCS = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCH*NCS-1:0] evt_i = '0;
  logic [NCH-1:0] busy_i = '0;
  logic [NCH-1:0] run_o;
  logic        irq_o;

  always #5 clk = ~clk;

  dma_irq_hub i_dma_irq_hub (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
    .busy_i(busy_i), .run_o(run_o), .irq_o(irq_o)
  );

  typedef struct {
    int          kind;   // 0 read data, 1 irq, 2 run outputs
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  item_t cur;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [11:0] A_PEND = 12'h000;
  localparam logic [11:0] A_GEN  = 12'h010;
  localparam logic [11:0] A_IDLE = 12'h02C;

  function automatic logic [11:0] ch_a(int c, int off);
    return 12'((c + 1) * 256 + off);
  endfunction

  // monitor: compares queued expectations away from the clock edge
  always begin
    @(negedge clk);
    #3;
    while (q.size() > 0) begin
      logic [31:0] act;
      cur = q.pop_front();
      if (cur.kind == 0) act = reg_rdata;
      else if (cur.kind == 1) act = {31'b0, irq_o};
      else act = {24'b0, run_o};
      checks++;
      if (act !== cur.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", cur.tag, act, cur.exp);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic exp_rd(logic [11:0] a, logic [31:0] e, string tag);
    reg_addr = a;
    q.push_back('{0, e, tag});
  endtask

  task automatic exp_irq(logic e, string tag);
    q.push_back('{1, {31'b0, e}, tag});
  endtask

  task automatic exp_run(logic [7:0] e, string tag);
    q.push_back('{2, {24'b0, e}, tag});
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
    exp_rd(a, e, tag);
    step(1);
  endtask

  task automatic pulse(int c, int k);
    evt_i[c*NCS + k] = 1'b1;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic pulse_and_wr(int c, int k, logic [11:0] a, logic [31:0] d);
    evt_i[c*NCS + k] = 1'b1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    evt_i = '0; reg_wr = 1'b0;
  endtask

  task automatic finish_run();
    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    rd(A_PEND, 0, "R1 pending");
    rd(A_GEN, 0, "R1 global enable");
    rd(ch_a(3, 4), 0, "R1 cause enable");
    exp_irq(1'b0, "R1 irq"); exp_run(8'h00, "R1 run");
    rd(ch_a(3, 8), 0, "R1 status");

    // R11 idle word
    busy_i = 8'hA5;
    rd(A_IDLE, 32'h5A, "R11 idle");
    busy_i = 8'h00;
    rd(A_IDLE, 32'hFF, "R11 idle all");

    // R12 run control
    wr(ch_a(2, 0), 1);
    exp_run(8'h04, "R12 run set"); rd(ch_a(2, 0), 1, "R12 run readback");
    wr(ch_a(2, 0), 0);
    exp_run(8'h00, "R12 run clear"); step(1);

    // R4 enables
    wr(ch_a(1, 4), 32'h1F);
    rd(ch_a(1, 4), 32'h1F, "R4 cause enable");
    wr(A_GEN, 32'hFF);
    rd(A_GEN, 32'hFF, "R4 global enable");

    // R2 R5 R9 timing of one event
    pulse(1, 2);
    exp_irq(1'b0, "R9 irq not yet");
    rd(ch_a(1, 8), 32'h04, "R2 status set");
    exp_irq(1'b0, "R9 irq still low");
    rd(A_PEND, 32'h02, "R5 pending set");
    exp_irq(1'b1, "R9 irq high");
    step(1);

    // R7 write-one-to-clear
    wr(A_PEND, 32'h00);
    rd(A_PEND, 32'h02, "R7 zero write keeps");
    wr(A_PEND, 32'h02);
    exp_irq(1'b1, "R9 irq registered");
    rd(A_PEND, 32'h00, "R7 pending cleared");
    exp_irq(1'b0, "R9 irq low");

    // R6 mismatch: status set, pending clear
    rd(ch_a(1, 8), 32'h04, "R6 status kept");
    pulse(1, 0);
    step(2);
    exp_irq(1'b0, "R6 irq");
    rd(A_PEND, 32'h00, "R6 no re-set");
    rd(ch_a(1, 8), 32'h05, "R2 second cause");

    // R3 status clear by zero bits
    wr(ch_a(1, 8), 32'h01);
    rd(ch_a(1, 8), 32'h01, "R3 partial clear");
    wr(ch_a(1, 8), 32'h00);
    rd(ch_a(1, 8), 32'h00, "R3 full clear");
    pulse(1, 0);
    step(2);
    rd(A_PEND, 32'h02, "R6 recovery");
    wr(A_PEND, 32'h02);
    wr(ch_a(1, 8), 32'h00);
    step(2);

    // R14 cause enable gating
    pulse(3, 1);
    step(2);
    rd(A_PEND, 32'h00, "R14 masked cause");
    rd(ch_a(3, 8), 32'h02, "R14 status recorded");
    wr(ch_a(3, 4), 32'h02);
    step(1);
    rd(A_PEND, 32'h08, "R5 enable raises");
    wr(A_PEND, 32'h08);
    wr(ch_a(3, 8), 32'h00);
    step(2);

    // R10 global enable mask
    wr(A_GEN, 32'hFE);
    wr(ch_a(0, 4), 32'h1F);
    pulse(0, 4);
    step(3);
    exp_irq(1'b0, "R10 masked irq");
    rd(A_PEND, 32'h01, "R10 pending recorded");
    wr(A_GEN, 32'hFF);
    exp_irq(1'b0, "R9 irq lag");
    step(1);
    exp_irq(1'b1, "R10 unmasked irq");
    wr(A_PEND, 32'h01);
    wr(ch_a(0, 8), 32'h00);
    step(2);
    exp_irq(1'b0, "R10 irq cleared");
    step(1);

    // R8 event wins over clear
    pulse_and_wr(5, 3, ch_a(5, 8), 32'h00);
    rd(ch_a(5, 8), 32'h08, "R8 status event wins");
    wr(ch_a(6, 4), 32'h1F);
    pulse(6, 0);
    wr(A_PEND, 32'h40);
    rd(A_PEND, 32'h40, "R8 pending event wins");
    wr(A_PEND, 32'h40);
    rd(A_PEND, 32'h00, "R7 pending cleared again");

    // R13 unmapped addresses
    wr(12'h904, 32'h1F);
    rd(12'h904, 32'h00, "R13 beyond channels");
    wr(12'h004, 32'hFF);
    rd(12'h004, 32'h00, "R13 global hole");
    rd(A_PEND, 32'h00, "R13 pending untouched");
    rd(A_GEN, 32'hFF, "R13 enable untouched");
    rd(ch_a(0, 4), 32'h1F, "R13 channel 0 untouched");

    done = 1'b1;
    finish_run();
  end
endmodule